// File: doc/BRIEF.md
# Sync Conditioning and Periodic Sync Generator

This block sits at the edge of a tuner channel. It turns the active-low sync lines into clean events and produces one active-low sync output for other channels or devices. The system, accumulator and gain sync inputs are captured on the rising clock edge. Each capture is reduced to a single-cycle active-high pulse that downstream timers and accumulators can act on.

The sync output has two sources, picked by a mode bit from the control register space. With the bit clear, the output repeats the system sync input after a fixed two-register pipeline. With the bit set, a free-running counter drives the output low for one clock every 2^PER_W clocks. PER_W defaults to 20 and can be made smaller to shorten the period. The block also decodes register writes: a write to trigger address 10 produces a one-clock active-low strobe.

Reset is asynchronous and active low. Internally it is released in step with the clock.

Top module: `sync_hub`

## Requirements
- R1: While reset is held and after it is released with idle inputs, sync_out_n and oneshot_n are 1 and all three pulse outputs are 0.
- R2: With gen_sel = 0, sync_out_n equals the level of sys_sync_n sampled two rising edges earlier.
- R3: With gen_sel = 1, sync_out_n goes low for exactly one clock every 2^PER_W clocks.
- R4: With gen_sel = 1, activity on sys_sync_n does not change the spacing or the width of the generated sync.
- R5: A write (wr_en = 1) with wr_addr = 10 drives oneshot_n low for exactly the one clock that follows the edge sampling the write.
- R6: A write to any address other than 10 leaves oneshot_n at 1.
- R7: A write to address 10 held over several clocks gives only one strobe. After the write is released, a fresh write gives a new strobe.
- R8: A high-to-low change on a sync input raises the matching pulse output (sys_pulse, acc_pulse, gain_pulse) for the one clock after the edge that first samples the low level. Holding the input low gives no further pulse.
- R9: The three pulse outputs are independent: a transition on one sync input raises only its own pulse output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_sync_n | input | 1 | System sync, active low |
| acc_sync_n | input | 1 | Accumulator sync, active low |
| gain_sync_n | input | 1 | Gain sync, active low |
| gen_sel | input | 1 | Output source: 0 = pipelined system sync, 1 = internal generator |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register address of the write |
| sync_out_n | output | 1 | Sync output, active low |
| oneshot_n | output | 1 | One-clock strobe, active low |
| sys_pulse | output | 1 | Active-high event for system sync |
| acc_pulse | output | 1 | Active-high event for accumulator sync |
| gain_pulse | output | 1 | Active-high event for gain sync |

## Verification
In copy mode the system sync is driven with a short low, a long low and a single-cycle low. These separate a correct two-clock delay from a one-clock or three-clock one, and catch a level that gets stretched. In generator mode the period is shortened to 16 clocks, and the gaps between generated lows are measured twice: once with the system sync idle and once while it toggles. A wrong wrap point or leakage from the external sync shows up as a changed gap. The write decode is tried with the trigger address, a neighbouring address, a held write and back-to-back fresh writes, which exposes a level-driven strobe or a loose compare. Each sync input is pulsed alone so that crossed channels show.

// File: rtl/sync_hub_pkg.sv
package sync_hub_pkg;
  typedef enum logic {
    SRC_PIPE = 1'b0,
    SRC_GEN  = 1'b1
  } sync_src_e;

  localparam int NUM_SYNC = 3;
  localparam int IDX_SYS  = 0;
  localparam int IDX_ACC  = 1;
  localparam int IDX_GAIN = 2;
endpackage

// File: rtl/sh_rst_sync.sv
module sh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sh_sync_edge.sv
module sh_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n_i,
  output logic sampled_n_o,
  output logic pulse_o
);
  logic smp_q, smp_d;
  logic hist_q, hist_d;

  always_comb begin
    smp_d  = sync_n_i;
    hist_d = smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      smp_q  <= smp_d;
      hist_q <= hist_d;
    end
  end

  assign sampled_n_o = smp_q;
  assign pulse_o     = hist_q & ~smp_q;

  // R8: a held-low input must not produce a second pulse
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
  // R8: a pulse follows a sampled low after a sampled high
  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sampled_n_o) |-> pulse_o);
endmodule

// File: rtl/sh_period_gen.sv
module sh_period_gen #(
  parameter int PER_W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  output logic tick_n_o
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == {PER_W{1'b1}});
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_n_o = ~(wrap & cnt_en);

  // R3: the generated tick lasts one clock and the count restarts from zero
  assert_tick_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_n_o |=> tick_n_o);
  assert_tick_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_n_o |=> (cnt_q == '0));
endmodule

// File: rtl/sh_oneshot.sv
module sh_oneshot #(
  parameter int ADDR_W    = 4,
  parameter int TRIG_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              strobe_n_o
);
  localparam logic [ADDR_W-1:0] TRIG_CODE = TRIG_ADDR[ADDR_W-1:0];

  logic hit;
  logic hit_q, hit_d;
  logic strobe_q, strobe_d;

  always_comb begin
    hit      = wr_en_i && (wr_addr_i == TRIG_CODE);
    hit_d    = hit;
    strobe_d = ~(hit & ~hit_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      strobe_q <= 1'b1;
    end else begin
      hit_q    <= hit_d;
      strobe_q <= strobe_d;
    end
  end

  assign strobe_n_o = strobe_q;

  // R5 / R7: strobe is one clock wide even for a held write
  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n_o |=> strobe_n_o);
  // R6: strobe only follows a write that matched the trigger address
  assert_strobe_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n_o |-> $past(wr_en_i && (wr_addr_i == TRIG_CODE)));
endmodule

// File: rtl/sync_hub.sv
module sync_hub
  import sync_hub_pkg::*;
#(
  parameter int PER_W     = 20,
  parameter int ADDR_W    = 4,
  parameter int TRIG_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_sync_n,
  input  logic              acc_sync_n,
  input  logic              gain_sync_n,
  input  logic              gen_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              sync_out_n,
  output logic              oneshot_n,
  output logic              sys_pulse,
  output logic              acc_pulse,
  output logic              gain_pulse
);
  logic                rst_int_n;
  logic [NUM_SYNC-1:0] sync_in_n;
  logic [NUM_SYNC-1:0] sampled_n;
  logic [NUM_SYNC-1:0] pulses;
  logic                gen_tick_n;
  sync_src_e           src;
  logic                out_q, out_d;

  sh_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    sync_in_n           = '1;
    sync_in_n[IDX_SYS]  = sys_sync_n;
    sync_in_n[IDX_ACC]  = acc_sync_n;
    sync_in_n[IDX_GAIN] = gain_sync_n;
  end

  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_edge
    sh_sync_edge u_edge (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .sync_n_i    (sync_in_n[i]),
      .sampled_n_o (sampled_n[i]),
      .pulse_o     (pulses[i])
    );
  end

  sh_period_gen #(.PER_W(PER_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cnt_en   (1'b1),
    .tick_n_o (gen_tick_n)
  );

  sh_oneshot #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_shot (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .strobe_n_o (oneshot_n)
  );

  always_comb begin
    src   = sync_src_e'(gen_sel);
    out_d = (src == SRC_GEN) ? gen_tick_n : sampled_n[IDX_SYS];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_q <= 1'b1;
    else            out_q <= out_d;
  end

  assign sync_out_n = out_q;
  assign sys_pulse  = pulses[IDX_SYS];
  assign acc_pulse  = pulses[IDX_ACC];
  assign gain_pulse = pulses[IDX_GAIN];

  // R2: in copy mode the output follows the sampled system sync one stage later
  assert_copy_path_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(gen_sel) == 1'b0) |-> (sync_out_n == $past(sampled_n[IDX_SYS])));
  // R4: in generator mode the output follows only the generator
  assert_gen_path_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(gen_sel) == 1'b1) |-> (sync_out_n == $past(gen_tick_n)));
  // R9: pulse outputs stay tied to their own channel
  assert_pulse_onehot_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sys_pulse |-> $fell(sampled_n[IDX_SYS])));
endmodule

// File: tb/tb_sync_hub.sv
module tb_sync_hub;
  localparam int PER_W  = 4;
  localparam int PERIOD = 1 << PER_W;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sys_sync_n, acc_sync_n, gain_sync_n;
  logic       gen_sel, wr_en;
  logic [3:0] wr_addr;
  logic       sync_out_n, oneshot_n, sys_pulse, acc_pulse, gain_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sync_hub #(.PER_W(PER_W), .ADDR_W(4), .TRIG_ADDR(10)) dut (
    .clk(clk), .rst_n(rst_n), .sys_sync_n(sys_sync_n), .acc_sync_n(acc_sync_n),
    .gain_sync_n(gain_sync_n), .gen_sel(gen_sel), .wr_en(wr_en), .wr_addr(wr_addr),
    .sync_out_n(sync_out_n), .oneshot_n(oneshot_n), .sys_pulse(sys_pulse),
    .acc_pulse(acc_pulse), .gain_pulse(gain_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset_R1;
    rst_n = 1'b0; sys_sync_n = 1'b1; acc_sync_n = 1'b1; gain_sync_n = 1'b1;
    gen_sel = 1'b0; wr_en = 1'b0; wr_addr = '0;
    step(3);
    chk(sync_out_n == 1'b1, "R1 sync_out_n in reset", sync_out_n, 1);
    chk(oneshot_n == 1'b1, "R1 oneshot_n in reset", oneshot_n, 1);
    chk({sys_pulse, acc_pulse, gain_pulse} == 3'b000, "R1 pulses in reset",
        {sys_pulse, acc_pulse, gain_pulse}, 0);
    rst_n = 1'b1;
    step(4);
    chk(sync_out_n == 1'b1 && oneshot_n == 1'b1, "R1 idle after release",
        {sync_out_n, oneshot_n}, 3);
  endtask

  task automatic t_copy_R2;
    // single low of three clocks
    sys_sync_n = 1'b0;
    step(1);
    chk(sync_out_n == 1'b1, "R2 no change after one edge", sync_out_n, 1);
    step(1);
    chk(sync_out_n == 1'b0, "R2 low after two edges", sync_out_n, 0);
    step(1);
    sys_sync_n = 1'b1;
    step(1);
    chk(sync_out_n == 1'b0, "R2 still low (held input)", sync_out_n, 0);
    step(1);
    chk(sync_out_n == 1'b1, "R2 back high two edges after release", sync_out_n, 1);
    // single-cycle low
    sys_sync_n = 1'b0;
    step(1);
    sys_sync_n = 1'b1;
    step(1);
    chk(sync_out_n == 1'b0, "R2 one-cycle low appears", sync_out_n, 0);
    step(1);
    chk(sync_out_n == 1'b1, "R2 one-cycle low not stretched", sync_out_n, 1);
  endtask

  task automatic measure_gen(input bit toggle, input string req);
    int lows[$];
    int wide = 0;
    for (int c = 0; c < 3 * PERIOD + 2; c++) begin
      if (toggle) sys_sync_n = ~sys_sync_n;
      step(1);
      if (sync_out_n == 1'b0) begin
        if (lows.size() > 0 && lows[lows.size()-1] == c - 1) wide++;
        lows.push_back(c);
      end
    end
    sys_sync_n = 1'b1;
    chk(lows.size() >= 2, {req, " generated lows seen"}, lows.size(), 3);
    chk(wide == 0, {req, " generated low one clock wide"}, wide, 0);
    if (lows.size() >= 2)
      chk(lows[1] - lows[0] == PERIOD, {req, " generated period"}, lows[1] - lows[0], PERIOD);
    if (lows.size() >= 3)
      chk(lows[2] - lows[1] == PERIOD, {req, " generated period repeat"},
          lows[2] - lows[1], PERIOD);
  endtask

  task automatic t_gen_R3;
    gen_sel = 1'b1;
    step(2);
    measure_gen(1'b0, "R3");
  endtask

  task automatic t_gen_isolated_R4;
    measure_gen(1'b1, "R4");
    gen_sel = 1'b0;
    step(3);
    chk(sync_out_n == 1'b1, "R4 copy mode restored", sync_out_n, 1);
  endtask

  task automatic t_shot_R5;
    wr_en = 1'b1; wr_addr = 4'd10;
    step(1);
    wr_en = 1'b0;
    chk(oneshot_n == 1'b0, "R5 strobe after trigger write", oneshot_n, 0);
    step(1);
    chk(oneshot_n == 1'b1, "R5 strobe one clock wide", oneshot_n, 1);
  endtask

  task automatic t_shot_other_R6;
    int lows = 0;
    wr_en = 1'b1;
    for (int a = 0; a < 16; a++) begin
      if (a == 10) continue;
      wr_addr = 4'(a);
      step(1);
      if (oneshot_n == 1'b0) lows++;
    end
    wr_en = 1'b0;
    step(1);
    if (oneshot_n == 1'b0) lows++;
    chk(lows == 0, "R6 no strobe for other addresses", lows, 0);
  endtask

  task automatic t_shot_held_R7;
    int lows = 0;
    wr_en = 1'b1; wr_addr = 4'd10;
    for (int c = 0; c < 4; c++) begin
      step(1);
      if (oneshot_n == 1'b0) lows++;
    end
    wr_en = 1'b0;
    step(1);
    if (oneshot_n == 1'b0) lows++;
    chk(lows == 1, "R7 held write gives one strobe", lows, 1);
    wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
    chk(oneshot_n == 1'b0, "R7 fresh write strobes again", oneshot_n, 0);
    step(1);
  endtask

  task automatic t_pulse_R8;
    int cnt = 0;
    acc_sync_n = 1'b0;
    step(1);
    chk(acc_pulse == 1'b1, "R8 pulse after first low sample", acc_pulse, 1);
    for (int c = 0; c < 5; c++) begin
      step(1);
      if (acc_pulse) cnt++;
    end
    chk(cnt == 0, "R8 no repeat while held low", cnt, 0);
    acc_sync_n = 1'b1;
    step(2);
    chk(acc_pulse == 1'b0, "R8 no pulse on rising edge", acc_pulse, 0);
  endtask

  task automatic t_channels_R9;
    gain_sync_n = 1'b0;
    step(1);
    chk({sys_pulse, acc_pulse, gain_pulse} == 3'b001, "R9 gain only",
        {sys_pulse, acc_pulse, gain_pulse}, 1);
    gain_sync_n = 1'b1;
    sys_sync_n = 1'b0;
    step(1);
    chk({sys_pulse, acc_pulse, gain_pulse} == 3'b100, "R9 sys only",
        {sys_pulse, acc_pulse, gain_pulse}, 4);
    sys_sync_n = 1'b1;
    acc_sync_n = 1'b0;
    step(1);
    chk({sys_pulse, acc_pulse, gain_pulse} == 3'b010, "R9 acc only",
        {sys_pulse, acc_pulse, gain_pulse}, 2);
    acc_sync_n = 1'b1;
    step(3);
  endtask

  initial begin
    t_reset_R1();
    t_copy_R2();
    t_gen_R3();
    t_gen_isolated_R4();
    t_shot_R5();
    t_shot_other_R6();
    t_shot_held_R7();
    t_pulse_R8();
    t_channels_R9();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule